// File: doc/BRIEF.md
# Bus Access Fault Decoder

This block watches every address phase on the system bus and decides, one cycle later, whether the access must be refused. Each request carries an address, a flag saying whether it is an instruction fetch, and a flag saying whether it is a write. The block sorts the address into one of the memory regions set by its parameters: flash, the special-register window below SRAM, SRAM, boot ROM, two optional external banks, and two 2 MB peripheral regions. Each peripheral region is cut into 128 slots of 16 kB. The response gives a data-abort flag, a fetch-abort flag, a cause code and one-hot slot selects for the two peripheral regions.

Fetches and data accesses follow different rules. Data reads and writes to any assigned peripheral slot or to the special-register window are legal. Offsets inside an assigned slot are not checked, so such an address may alias onto a defined register. An instruction fetch from those same spaces is refused. A data write straight into flash is refused. An address outside every implemented region, or one that falls in an unassigned slot, is refused for any kind of access. A refused fetch is only tagged on the response. The consumer decides whether to act on it, so a prefetched word that never executes costs nothing.

Top module: `bus_fault_decoder`

## Requirements
- R1: While rst_n is low, and after its release until the first request is captured, every response output is zero.
- R2: A request presented with req_valid high at a rising clock edge is answered on the response outputs one cycle later, with rsp_valid high for that cycle. A cycle with req_valid low yields rsp_valid low and all response outputs zero.
- R3: An address in no implemented region aborts with rsp_cause = 1. The implemented regions are flash 0x00000000–0x0007FFFF, special registers 0x3FFF8000–0x3FFFFFFF, SRAM 0x40000000–0x4000FFFF, boot ROM 0x7FFFE000–0x7FFFFFFF, external banks 0x80000000–0x8000FFFF and 0x81000000–0x8100FFFF, APB 0xE0000000–0xE01FFFFF and AHB 0xFFE00000–0xFFFFFFFF.
- R4: An access to a peripheral slot whose bit is clear in the slot map aborts with rsp_cause = 2, for both data accesses and fetches. The slot index is address bits 20:14.
- R5: A data access to an assigned slot does not abort and sets exactly one select bit. That bit is bit addr[20:14] of rsp_apb_sel for the APB region, or of rsp_ahb_sel for the AHB region. Address bits 13:0 do not change the result.
- R6: A fetch from an assigned peripheral slot or from 0x3FFF8000–0x3FFFFFFF raises rsp_fetch_abort with rsp_cause = 3. A data access to the special-register window is legal.
- R7: A data write to flash raises rsp_data_abort with rsp_cause = 4. Reads and fetches from flash are legal.
- R8: When req_fetch is high, req_write is ignored and any fault is reported on rsp_fetch_abort, never on rsp_data_abort. When req_fetch is low, any fault is reported on rsp_data_abort.
- R9: Reads, writes and fetches in SRAM, boot ROM and the external banks are legal.
- R10: The causes rank unmapped (1) over unassigned slot (2) over peripheral fetch (3) over flash write (4). Cause 0 means no fault. At most one abort flag is high. Whenever a fault is reported, both select vectors are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Address phase present |
| req_addr | input | 32 | Byte address of the access |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_write | input | 1 | Access is a data write |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_data_abort | output | 1 | Data access refused |
| rsp_fetch_abort | output | 1 | Fetch refused (tag only) |
| rsp_cause | output | 3 | Fault cause code, 0 when none |
| rsp_apb_sel | output | 128 | One-hot APB slot select |
| rsp_ahb_sel | output | 128 | One-hot AHB slot select |

## Verification
The assertions assume that req_fetch, req_write and req_addr are known whenever req_valid is high. They also assume the inputs change only away from the sampling edge. The stimulus holds all request inputs at defined values from time zero and changes them on the falling edge. Random addresses are built from the region bases plus a masked offset. This keeps most samples near region edges, slot boundaries and alias offsets, where the ranking of causes matters. Fetch and write flags are drawn independently, so fetch-with-write combinations occur.

// File: rtl/bfd_pkg.sv
// bfd_pkg
// Shared types for the bus access fault decoder: cause codes, the region
// hit vector and a range helper. Assumes a 32-bit byte address.
package bfd_pkg;

    localparam int AW = 32;

    // Fault cause codes; lower nonzero value wins when several apply.
    typedef enum logic [2:0] {
        CAUSE_NONE         = 3'd0,
        CAUSE_UNMAPPED     = 3'd1,
        CAUSE_SLOT_EMPTY   = 3'd2,
        CAUSE_FETCH_PERIPH = 3'd3,
        CAUSE_FLASH_WRITE  = 3'd4
    } fault_cause_e;

    // One flag per implemented region.
    typedef struct packed {
        logic flash;
        logic special;
        logic sram;
        logic boot;
        logic ext;
        logic apb;
        logic ahb;
    } region_hit_t;

    // True when addr lies in [base, base+bytes).
    function automatic logic in_range(input logic [AW-1:0] addr,
                                      input logic [AW-1:0] base,
                                      input logic [AW-1:0] bytes);
        logic [AW-1:0] off;
        off = addr - base;
        return (addr >= base) && (off < bytes);
    endfunction

endpackage

// File: rtl/bfd_region_decode.sv
// bfd_region_decode
// Sorts a byte address into the implemented regions. Purely combinational.
// Assumes regions do not overlap and peripheral regions are aligned to
// their own size (a power of two).
module bfd_region_decode
    import bfd_pkg::*;
#(
    parameter logic [AW-1:0] FLASH_BYTES   = 32'h0008_0000,
    parameter logic [AW-1:0] SPECIAL_BASE  = 32'h3FFF_8000,
    parameter logic [AW-1:0] SPECIAL_BYTES = 32'h0000_8000,
    parameter logic [AW-1:0] SRAM_BASE     = 32'h4000_0000,
    parameter logic [AW-1:0] SRAM_BYTES    = 32'h0001_0000,
    parameter logic [AW-1:0] BOOT_BASE     = 32'h7FFF_E000,
    parameter logic [AW-1:0] BOOT_BYTES    = 32'h0000_2000,
    parameter bit            EXT_EN        = 1'b1,
    parameter logic [AW-1:0] EXT_BASE0     = 32'h8000_0000,
    parameter logic [AW-1:0] EXT_BASE1     = 32'h8100_0000,
    parameter logic [AW-1:0] EXT_BYTES     = 32'h0001_0000,
    parameter logic [AW-1:0] APB_BASE      = 32'hE000_0000,
    parameter logic [AW-1:0] AHB_BASE      = 32'hFFE0_0000,
    parameter int            PERIPH_LSB    = 21
) (
    input  logic [AW-1:0] addr,
    output region_hit_t   hit
);

    logic ext_hit;

    // External banks exist only when enabled by parameter.
    generate
        if (EXT_EN) begin : g_ext
            assign ext_hit = in_range(addr, EXT_BASE0, EXT_BYTES) ||
                             in_range(addr, EXT_BASE1, EXT_BYTES);
        end else begin : g_no_ext
            assign ext_hit = 1'b0;
        end
    endgenerate

    // Compare the address against every region window.
    always_comb begin
        hit.flash   = in_range(addr, '0, FLASH_BYTES);
        hit.special = in_range(addr, SPECIAL_BASE, SPECIAL_BYTES);
        hit.sram    = in_range(addr, SRAM_BASE, SRAM_BYTES);
        hit.boot    = in_range(addr, BOOT_BASE, BOOT_BYTES);
        hit.ext     = ext_hit;
        hit.apb     = (addr[AW-1:PERIPH_LSB] == APB_BASE[AW-1:PERIPH_LSB]);
        hit.ahb     = (addr[AW-1:PERIPH_LSB] == AHB_BASE[AW-1:PERIPH_LSB]);
    end

endmodule

// File: rtl/bfd_slot_decode.sv
// bfd_slot_decode
// Turns a slot index into a one-hot select, masked by the slot map and by
// the region hit. Offsets inside a slot never reach this module, so any
// alias of an assigned slot selects that slot.
module bfd_slot_decode #(
    parameter int               NSLOT = 128,
    parameter logic [NSLOT-1:0] MAP   = '1,
    localparam int              IDX_W = $clog2(NSLOT)
) (
    input  logic             in_region,
    input  logic [IDX_W-1:0] idx,
    output logic [NSLOT-1:0] sel,
    output logic             assigned
);

    // One comparator per slot, present only for assigned slots.
    generate
        for (genvar i = 0; i < NSLOT; i++) begin : g_slot
            if (MAP[i]) begin : g_on
                assign sel[i] = in_region && (idx == IDX_W'(i));
            end else begin : g_off
                assign sel[i] = 1'b0;
            end
        end
    endgenerate

    // A hit in the region that selects nothing is an empty slot.
    assign assigned = |sel;

endmodule

// File: rtl/bfd_fault_resolve.sv
// bfd_fault_resolve
// Ranks the fault causes for one request and registers the response.
// Assumes region hits and slot selects come from the same address phase.
module bfd_fault_resolve
    import bfd_pkg::*;
#(
    parameter int NSLOT = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_fetch,
    input  logic             req_write,
    input  region_hit_t      hit,
    input  logic             apb_assigned,
    input  logic             ahb_assigned,
    input  logic [NSLOT-1:0] apb_sel_in,
    input  logic [NSLOT-1:0] ahb_sel_in,
    output logic             rsp_valid,
    output logic             rsp_data_abort,
    output logic             rsp_fetch_abort,
    output fault_cause_e     rsp_cause,
    output logic [NSLOT-1:0] rsp_apb_sel,
    output logic [NSLOT-1:0] rsp_ahb_sel
);

    fault_cause_e cause_n;
    logic         any_hit;
    logic         periph;
    logic         slot_empty;

    // Pick the highest-ranked cause for the current request.
    always_comb begin
        any_hit    = |hit;
        periph     = hit.apb || hit.ahb;
        slot_empty = (hit.apb && !apb_assigned) || (hit.ahb && !ahb_assigned);
        if (!any_hit)
            cause_n = CAUSE_UNMAPPED;
        else if (slot_empty)
            cause_n = CAUSE_SLOT_EMPTY;
        else if (req_fetch && (periph || hit.special))
            cause_n = CAUSE_FETCH_PERIPH;
        else if (!req_fetch && req_write && hit.flash)
            cause_n = CAUSE_FLASH_WRITE;
        else
            cause_n = CAUSE_NONE;
    end

    // Register the response; idle cycles clear every output.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_valid       <= 1'b0;
            rsp_data_abort  <= 1'b0;
            rsp_fetch_abort <= 1'b0;
            rsp_cause       <= CAUSE_NONE;
            rsp_apb_sel     <= '0;
            rsp_ahb_sel     <= '0;
        end else begin
            rsp_valid       <= 1'b1;
            rsp_data_abort  <= (cause_n != CAUSE_NONE) && !req_fetch;
            rsp_fetch_abort <= (cause_n != CAUSE_NONE) && req_fetch;
            rsp_cause       <= cause_n;
            rsp_apb_sel     <= (cause_n == CAUSE_NONE) ? apb_sel_in : '0;
            rsp_ahb_sel     <= (cause_n == CAUSE_NONE) ? ahb_sel_in : '0;
        end
    end

endmodule

// File: rtl/bus_fault_decoder.sv
// bus_fault_decoder
// Top of the bus access fault decoder. Classifies each address phase,
// refuses illegal accesses one cycle later and drives one-hot peripheral
// slot selects for legal ones. Assumes inputs are stable around the edge.
module bus_fault_decoder
    import bfd_pkg::*;
#(
    parameter logic [31:0]  FLASH_BYTES   = 32'h0008_0000,
    parameter logic [31:0]  SPECIAL_BASE  = 32'h3FFF_8000,
    parameter logic [31:0]  SRAM_BASE     = 32'h4000_0000,
    parameter logic [31:0]  SRAM_BYTES    = 32'h0001_0000,
    parameter logic [31:0]  BOOT_BYTES    = 32'h0000_2000,
    parameter bit           EXT_EN        = 1'b1,
    parameter logic [31:0]  EXT_BASE0     = 32'h8000_0000,
    parameter logic [31:0]  EXT_BASE1     = 32'h8100_0000,
    parameter logic [31:0]  EXT_BYTES     = 32'h0001_0000,
    parameter logic [31:0]  APB_BASE      = 32'hE000_0000,
    parameter logic [31:0]  AHB_BASE      = 32'hFFE0_0000,
    parameter logic [31:0]  PERIPH_BYTES  = 32'h0020_0000,
    parameter int           NSLOT         = 128,
    parameter logic [127:0] APB_MAP       = 128'h8000_0000_0000_0000_0000_000F_FC87_FFDF,
    parameter logic [127:0] AHB_MAP       = 128'h8000_0000_0000_0000_0000_0000_0000_001F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  logic [31:0]  req_addr,
    input  logic         req_fetch,
    input  logic         req_write,
    output logic         rsp_valid,
    output logic         rsp_data_abort,
    output logic         rsp_fetch_abort,
    output logic [2:0]   rsp_cause,
    output logic [127:0] rsp_apb_sel,
    output logic [127:0] rsp_ahb_sel
);

    localparam int          PERIPH_LSB    = $clog2(PERIPH_BYTES);
    localparam int          IDX_W         = $clog2(NSLOT);
    localparam int          SLOT_LSB      = PERIPH_LSB - IDX_W;
    localparam logic [31:0] SPECIAL_BYTES = SRAM_BASE - SPECIAL_BASE;
    localparam logic [31:0] BOOT_BASE     = 32'h8000_0000 - BOOT_BYTES;

    region_hit_t      hit;
    logic [IDX_W-1:0] slot_idx;
    logic [NSLOT-1:0] apb_sel_c;
    logic [NSLOT-1:0] ahb_sel_c;
    logic             apb_assigned;
    logic             ahb_assigned;
    fault_cause_e     cause_q;

    assign slot_idx  = req_addr[SLOT_LSB +: IDX_W];
    assign rsp_cause = cause_q;

    bfd_region_decode #(
        .FLASH_BYTES  (FLASH_BYTES),
        .SPECIAL_BASE (SPECIAL_BASE),
        .SPECIAL_BYTES(SPECIAL_BYTES),
        .SRAM_BASE    (SRAM_BASE),
        .SRAM_BYTES   (SRAM_BYTES),
        .BOOT_BASE    (BOOT_BASE),
        .BOOT_BYTES   (BOOT_BYTES),
        .EXT_EN       (EXT_EN),
        .EXT_BASE0    (EXT_BASE0),
        .EXT_BASE1    (EXT_BASE1),
        .EXT_BYTES    (EXT_BYTES),
        .APB_BASE     (APB_BASE),
        .AHB_BASE     (AHB_BASE),
        .PERIPH_LSB   (PERIPH_LSB)
    ) u_region (
        .addr(req_addr),
        .hit (hit)
    );

    bfd_slot_decode #(
        .NSLOT(NSLOT),
        .MAP  (APB_MAP[NSLOT-1:0])
    ) u_apb_slots (
        .in_region(hit.apb),
        .idx      (slot_idx),
        .sel      (apb_sel_c),
        .assigned (apb_assigned)
    );

    bfd_slot_decode #(
        .NSLOT(NSLOT),
        .MAP  (AHB_MAP[NSLOT-1:0])
    ) u_ahb_slots (
        .in_region(hit.ahb),
        .idx      (slot_idx),
        .sel      (ahb_sel_c),
        .assigned (ahb_assigned)
    );

    bfd_fault_resolve #(
        .NSLOT(NSLOT)
    ) u_resolve (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_fetch      (req_fetch),
        .req_write      (req_write),
        .hit            (hit),
        .apb_assigned   (apb_assigned),
        .ahb_assigned   (ahb_assigned),
        .apb_sel_in     (apb_sel_c),
        .ahb_sel_in     (ahb_sel_c),
        .rsp_valid      (rsp_valid),
        .rsp_data_abort (rsp_data_abort),
        .rsp_fetch_abort(rsp_fetch_abort),
        .rsp_cause      (cause_q),
        .rsp_apb_sel    (rsp_apb_sel),
        .rsp_ahb_sel    (rsp_ahb_sel)
    );

endmodule

// File: rtl/bus_fault_decoder_chk.sv
// bus_fault_decoder_chk
// Temporal checks on the decoder's ports. Assumes request inputs are known
// whenever req_valid is high.
module bus_fault_decoder_chk #(
    parameter logic [31:0] FLASH_BYTES  = 32'h0008_0000,
    parameter logic [31:0] APB_BASE     = 32'hE000_0000,
    parameter logic [31:0] PERIPH_BYTES = 32'h0020_0000
) (
    input logic         clk,
    input logic         rst_n,
    input logic         req_valid,
    input logic [31:0]  req_addr,
    input logic         req_fetch,
    input logic         req_write,
    input logic         rsp_valid,
    input logic         rsp_data_abort,
    input logic         rsp_fetch_abort,
    input logic [2:0]   rsp_cause,
    input logic [127:0] rsp_apb_sel,
    input logic [127:0] rsp_ahb_sel
);

    localparam int PLSB = $clog2(PERIPH_BYTES);

    logic apb_hit;
    assign apb_hit = (req_addr[31:PLSB] == APB_BASE[31:PLSB]);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && !rsp_data_abort && !rsp_fetch_abort);

    a_r10_one_abort: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_data_abort && rsp_fetch_abort));

    a_r10_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_apb_sel, rsp_ahb_sel}));

    a_r10_no_sel_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_data_abort || rsp_fetch_abort) |-> (rsp_apb_sel == '0) && (rsp_ahb_sel == '0));

    a_r6_fetch_apb_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fetch && apb_hit) |=> rsp_fetch_abort);

    a_r7_flash_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_fetch && (req_addr < FLASH_BYTES))
        |=> rsp_data_abort && (rsp_cause == 3'd4));

    a_r8_fetch_no_data_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fetch) |=> !rsp_data_abort);

endmodule

bind bus_fault_decoder bus_fault_decoder_chk #(
    .FLASH_BYTES (FLASH_BYTES),
    .APB_BASE    (APB_BASE),
    .PERIPH_BYTES(PERIPH_BYTES)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_addr       (req_addr),
    .req_fetch      (req_fetch),
    .req_write      (req_write),
    .rsp_valid      (rsp_valid),
    .rsp_data_abort (rsp_data_abort),
    .rsp_fetch_abort(rsp_fetch_abort),
    .rsp_cause      (rsp_cause),
    .rsp_apb_sel    (rsp_apb_sel),
    .rsp_ahb_sel    (rsp_ahb_sel)
);

// File: tb/bus_fault_decoder_tb.sv
module bus_fault_decoder_tb;

    localparam logic [127:0] APB_M = 128'h8000_0000_0000_0000_0000_000F_FC87_FFDF;
    localparam logic [127:0] AHB_M = 128'h8000_0000_0000_0000_0000_0000_0000_001F;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_addr = '0;
    logic         req_fetch = 1'b0;
    logic         req_write = 1'b0;
    logic         rsp_valid, rsp_data_abort, rsp_fetch_abort;
    logic [2:0]   rsp_cause;
    logic [127:0] rsp_apb_sel, rsp_ahb_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bus_fault_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_fetch(req_fetch), .req_write(req_write), .rsp_valid(rsp_valid),
        .rsp_data_abort(rsp_data_abort), .rsp_fetch_abort(rsp_fetch_abort),
        .rsp_cause(rsp_cause), .rsp_apb_sel(rsp_apb_sel), .rsp_ahb_sel(rsp_ahb_sel)
    );

    function automatic logic in_win(logic [31:0] a, logic [31:0] lo, logic [31:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

    // Expected cause from the requirement tables (R3, R4, R6, R7, R10).
    function automatic logic [2:0] exp_cause(logic [31:0] a, logic f, logic w);
        logic apb, ahb, special, flash, known;
        logic [6:0] s;
        apb     = (a[31:21] == 11'h700);
        ahb     = (a[31:21] == 11'h7FF);
        special = in_win(a, 32'h3FFF_8000, 32'h3FFF_FFFF);
        flash   = in_win(a, 32'h0000_0000, 32'h0007_FFFF);
        known   = flash || special || apb || ahb ||
                  in_win(a, 32'h4000_0000, 32'h4000_FFFF) ||
                  in_win(a, 32'h7FFF_E000, 32'h7FFF_FFFF) ||
                  in_win(a, 32'h8000_0000, 32'h8000_FFFF) ||
                  in_win(a, 32'h8100_0000, 32'h8100_FFFF);
        s = a[20:14];
        if (!known) return 3'd1;
        if ((apb && !APB_M[s]) || (ahb && !AHB_M[s])) return 3'd2;
        if (f && (apb || ahb || special)) return 3'd3;
        if (!f && w && flash) return 3'd4;
        return 3'd0;
    endfunction

    function automatic string tag_of(logic [31:0] a, logic [2:0] c);
        case (c)
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R6";
            3'd4: return "R7";
            default: return (a[31:21] == 11'h700 || a[31:21] == 11'h7FF) ? "R5" : "R9";
        endcase
    endfunction

    // Drive one request, sample its response after the next edge.
    task automatic access(logic [31:0] a, logic f, logic w, string tag);
        logic [2:0]   c;
        logic [127:0] ea, eh;
        logic         eda, efa;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_fetch = f; req_write = w;
        @(posedge clk); #2;
        c   = exp_cause(a, f, w);
        eda = (c != 0) && !f;
        efa = (c != 0) && f;
        ea  = (c == 0 && a[31:21] == 11'h700) ? (128'd1 << a[20:14]) : '0;
        eh  = (c == 0 && a[31:21] == 11'h7FF) ? (128'd1 << a[20:14]) : '0;
        checks++;
        if (rsp_valid !== 1'b1 || rsp_cause !== c || rsp_data_abort !== eda ||
            rsp_fetch_abort !== efa || rsp_apb_sel !== ea || rsp_ahb_sel !== eh) begin
            errors++;
            $display("FAIL %s/R10 addr=%h f=%0b w=%0b: v=%0b da=%0b fa=%0b cause=%0d apb=%h ahb=%h, expected da=%0b fa=%0b cause=%0d apb=%h ahb=%h",
                     tag, a, f, w, rsp_valid, rsp_data_abort, rsp_fetch_abort, rsp_cause,
                     rsp_apb_sel, rsp_ahb_sel, eda, efa, c, ea, eh);
        end
    endtask

    task automatic idle_check(string tag);
        @(negedge clk);
        req_valid = 1'b0; req_addr = 32'hE000_C000; req_fetch = 1'b1; req_write = 1'b1;
        @(posedge clk); #2;
        checks++;
        if (rsp_valid !== 0 || rsp_data_abort !== 0 || rsp_fetch_abort !== 0 ||
            rsp_cause !== 0 || rsp_apb_sel !== '0 || rsp_ahb_sel !== '0) begin
            errors++;
            $display("FAIL %s idle: v=%0b da=%0b fa=%0b cause=%0d, expected all zero",
                     tag, rsp_valid, rsp_data_abort, rsp_fetch_abort, rsp_cause);
        end
        req_fetch = 1'b0; req_write = 1'b0;
    endtask

    initial begin
        logic [31:0] bases [12];
        logic [31:0] masks [12];
        bases = '{32'h0000_0000, 32'h0007_FFF0, 32'h3FFF_8000, 32'h4000_0000,
                  32'h7FFF_E000, 32'h8000_0000, 32'h8100_0000, 32'hE000_0000,
                  32'hFFE0_0000, 32'h9000_0000, 32'h0008_0000, 32'h4000_FFF0};
        masks = '{32'h0007_FFFF, 32'h0000_001F, 32'h0000_7FFF, 32'h0001_FFFF,
                  32'h0000_3FFF, 32'h0001_FFFF, 32'h0001_FFFF, 32'h001F_FFFF,
                  32'h001F_FFFF, 32'h0FFF_FFFF, 32'h0000_00FF, 32'h0000_001F};
        void'($urandom(32'd20240611));

        // R1: reset holds every output low.
        repeat (3) @(posedge clk);
        #2; checks++;
        if (rsp_valid !== 0 || rsp_data_abort !== 0 || rsp_fetch_abort !== 0 ||
            rsp_cause !== 0 || rsp_apb_sel !== '0 || rsp_ahb_sel !== '0) begin
            errors++;
            $display("FAIL R1 reset: v=%0b da=%0b fa=%0b cause=%0d, expected all zero",
                     rsp_valid, rsp_data_abort, rsp_fetch_abort, rsp_cause);
        end
        @(negedge clk); rst_n = 1'b1;
        idle_check("R1");

        // Directed corners.
        access(32'hE000_C000, 0, 0, "R5");   // assigned APB slot 3
        access(32'hE000_D004, 0, 1, "R5");   // alias inside slot 3
        access(32'hFFFF_C000, 0, 0, "R5");   // AHB slot 127
        idle_check("R2");
        access(32'hE001_4000, 0, 0, "R4");   // unassigned APB slot 5
        access(32'hE001_4000, 1, 0, "R4");
        access(32'hFFE2_0000, 0, 1, "R4");   // unassigned AHB slot 8
        access(32'hE000_C000, 1, 0, "R6");   // fetch from peripheral
        access(32'h3FFF_8000, 1, 0, "R6");   // fetch from special window
        access(32'h3FFF_FFFC, 0, 1, "R6");   // data access there is legal
        access(32'h0000_0100, 0, 1, "R7");   // flash write
        access(32'h0000_0100, 0, 0, "R7");   // flash read
        access(32'h0000_0100, 1, 1, "R8");   // fetch wins over write
        access(32'h9000_0000, 1, 0, "R8");   // unmapped fetch
        access(32'h9000_0000, 0, 1, "R3");   // unmapped data
        access(32'h0008_0000, 0, 0, "R3");   // just past flash
        access(32'h4000_0000, 0, 1, "R9");
        access(32'h7FFF_E000, 1, 0, "R9");
        access(32'h8100_0010, 0, 1, "R9");
        access(32'h8001_0000, 0, 0, "R3");   // just past bank 0

        // Random mix around region bases.
        for (int i = 0; i < 3000; i++) begin
            int k;
            logic [31:0] a;
            k = int'($urandom_range(0, 11));
            a = bases[k] + ($urandom & masks[k]);
            access(a, 1'($urandom), 1'($urandom), tag_of(a, exp_cause(a, 0, 0)));
            if (($urandom & 32'h1F) == 0) idle_check("R2");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200_000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule